// File: doc/BRIEF.md
# NOR Flash Word Program Sequencer

This block programs a run of words into a parallel NOR-style flash device without software help. After a start request it takes one source word at a time from a valid/ready stream. For each word it drives the three unlock-and-program command writes followed by the data write to the destination. It then reads the destination back until the device reports that its internal write has finished. The destination advances by the bus width in bytes after each good word, and the run stops when the word count is used up or a word fails.

Completion is detected by data polling. The masked bits of the read value are compared with the written value. While the status bit still differs, a second status bit, found two positions below the poll bit, flags an internal timeout in the device. When that flag is seen, the engine makes one confirming reread and fails the run only if that reread still mismatches. A mode input selects a simpler scheme that watches bit 7 alone and never gives up.

A host uses the block by setting the configuration inputs, pulsing the start request, and waiting for the one-cycle done pulse. It then reads the final status (0x80 good, 0x00 failed) and the number of words left.

Top module: `nor_prog_engine`

## Requirements
- R1: During and right after reset, busy, done, srcReady, flWe and flRe are all low.
- R2: For every word, four write strobes are issued on consecutive cycles, in this order: cfgUnlockCmd1 to cfgUnlockAddr1, cfgUnlockCmd2 to cfgUnlockAddr2, cfgProgCmd to cfgUnlockAddr1, then the source word to the current destination. Command and data values are cut to the bus width.
- R3: After the data write, the destination is read. The word is complete when ((written XOR read) AND cfgPollMask AND lane mask) is zero.
- R4: If that check fails and (read AND (cfgPollMask >> 2)) is zero, reading continues. If it is nonzero, exactly one more read is made, and the word succeeds if that read passes the R3 check.
- R5: If the confirming read of R4 also fails, the run stops at once with runStatus 0x00. remaining then holds the count of words not yet completed, including the failed word.
- R6: When every word succeeds, runStatus is 0x80 and remaining is 0.
- R7: cfgBusWidth 0, 1 and 2 select 8-, 16- and 32-bit words. The destination advances by 1, 2 or 4 per word, wrapping at the address width. Write data bits above the width are zero.
- R8: With cfgDq7Only set, only bit 7 of (written XOR read) is tested. Polling continues until it clears, whatever the DQ5 position shows.
- R9: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse with busy low. runStatus and remaining stay unchanged after done until the next start.
- R10: srcReady is high only while the engine waits to begin a word's command writes. Exactly one source word is consumed per word attempted.
- R11: A start request while busy is ignored: the running job keeps its addresses and word count.
- R12: A word count of 0 gives done on the cycle after start, with runStatus 0x80, remaining 0 and no flash access.
- R13: flRData is sampled on the cycle after flRe, and that sampling cycle carries no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start a run (accepted when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| runStatus | output | 8 | 0x80 success, 0x00 failure |
| remaining | output | CNT_W | Words still to be programmed |
| cfgUnlockAddr1 | input | ADDR_W | First unlock address (also program command address) |
| cfgUnlockAddr2 | input | ADDR_W | Second unlock address |
| cfgUnlockCmd1 | input | DATA_W | First unlock command value |
| cfgUnlockCmd2 | input | DATA_W | Second unlock command value |
| cfgProgCmd | input | DATA_W | Program command value |
| cfgStartAddr | input | ADDR_W | First destination address (captured at start) |
| cfgWordCount | input | CNT_W | Number of words (captured at start) |
| cfgBusWidth | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit (captured at start) |
| cfgPollMask | input | DATA_W | Data-poll bit mask; shifted right by 2 for the timeout bit |
| cfgDq7Only | input | 1 | Bit-7-only polling mode (captured at start) |
| srcData | input | DATA_W | Source word |
| srcValid | input | 1 | Source word valid |
| srcReady | output | 1 | Engine takes a source word |
| flAddr | output | ADDR_W | Flash bus address |
| flWData | output | DATA_W | Flash write data |
| flWe | output | 1 | Flash write strobe |
| flRe | output | 1 | Flash read strobe |
| flRData | input | DATA_W | Flash read data, valid the cycle after flRe |

## Verification
The embedded properties check on every cycle that done lasts one cycle, that the source is only offered while a run is active and no strobe is up, and that a read strobe is followed by a quiet sampling cycle. They also check that the word counter moves only by one on an advance and otherwise holds, and that success and failure leave the stated status values. The order and content of the command writes, the address stepping per width, the timeout confirmation path and its failure outcome, the bit-7-only mode and an ignored mid-run start can only be shown by the bench's scenarios. These scenarios run against a modelled flash that replays chosen busy, timeout and recovery patterns per word.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  // which address/data pair the datapath places on the flash bus
  typedef enum logic [1:0] {
    BUS_UNLOCK1 = 2'd0,
    BUS_UNLOCK2 = 2'd1,
    BUS_PROGCMD = 2'd2,
    BUS_DEST    = 2'd3
  } busSelE;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic   load;     // capture run configuration
    logic   capture;  // take a source word
    logic   advance;  // word finished: step address, drop count
    logic   setOk;    // final status good
    logic   setFail;  // final status bad
    busSelE busSel;
  } dpCtrlT;

endpackage

// File: rtl/nor_prog_dpath.sv
module nor_prog_dpath
  import nor_prog_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            dpCtrl,
  input  logic [ADDR_W-1:0] cfgUnlockAddr1,
  input  logic [ADDR_W-1:0] cfgUnlockAddr2,
  input  logic [DATA_W-1:0] cfgUnlockCmd1,
  input  logic [DATA_W-1:0] cfgUnlockCmd2,
  input  logic [DATA_W-1:0] cfgProgCmd,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [CNT_W-1:0]  cfgWordCount,
  input  logic [1:0]        cfgBusWidth,
  input  logic [DATA_W-1:0] cfgPollMask,
  input  logic              cfgDq7Only,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] flRData,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWData,
  output logic [CNT_W-1:0]  remaining,
  output logic [7:0]        runStatus,
  output logic              zeroCount,
  output logic              lastWord,
  output logic              pollOk,
  output logic              dq5High,
  output logic              dq7Only
);

  localparam logic [7:0] STAT_OK   = 8'h80;
  localparam logic [7:0] STAT_FAIL = 8'h00;

  logic [ADDR_W-1:0] destAddr;
  logic [DATA_W-1:0] wordReg;
  logic [CNT_W-1:0]  remReg;
  logic [7:0]        statusReg;
  logic [1:0]        widthReg;
  logic              dq7Reg;

  int                laneBits;
  logic [DATA_W-1:0] laneMask;
  logic [ADDR_W-1:0] addrStep;
  logic [DATA_W-1:0] diff;

  always_comb begin
    case (widthReg)
      2'd0:    begin laneBits = 8;  addrStep = ADDR_W'(1); end
      2'd1:    begin laneBits = 16; addrStep = ADDR_W'(2); end
      default: begin laneBits = 32; addrStep = ADDR_W'(4); end
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign laneMask[i] = (i < laneBits);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destAddr  <= '0;
      wordReg   <= '0;
      remReg    <= '0;
      statusReg <= STAT_FAIL;
      widthReg  <= '0;
      dq7Reg    <= 1'b0;
    end else begin
      if (dpCtrl.load) begin
        destAddr  <= cfgStartAddr;
        remReg    <= cfgWordCount;
        widthReg  <= cfgBusWidth;
        dq7Reg    <= cfgDq7Only;
        statusReg <= (cfgWordCount == '0) ? STAT_OK : STAT_FAIL;
      end
      if (dpCtrl.capture) wordReg <= srcData & laneMask;
      if (dpCtrl.advance) begin
        destAddr <= destAddr + addrStep;
        remReg   <= remReg - CNT_W'(1);
      end
      if (dpCtrl.setOk)   statusReg <= STAT_OK;
      if (dpCtrl.setFail) statusReg <= STAT_FAIL;
    end
  end

  always_comb begin
    case (dpCtrl.busSel)
      BUS_UNLOCK1: begin flAddr = cfgUnlockAddr1; flWData = cfgUnlockCmd1 & laneMask; end
      BUS_UNLOCK2: begin flAddr = cfgUnlockAddr2; flWData = cfgUnlockCmd2 & laneMask; end
      BUS_PROGCMD: begin flAddr = cfgUnlockAddr1; flWData = cfgProgCmd & laneMask; end
      default:     begin flAddr = destAddr;       flWData = wordReg; end
    endcase
  end

  assign diff      = wordReg ^ flRData;
  assign pollOk    = dq7Reg ? ~diff[7] : ((diff & cfgPollMask & laneMask) == '0);
  assign dq5High   = |(flRData & (cfgPollMask >> 2) & laneMask);
  assign zeroCount = (cfgWordCount == '0);
  assign lastWord  = (remReg == CNT_W'(1));
  assign dq7Only   = dq7Reg;
  assign remaining = remReg;
  assign runStatus = statusReg;

  // R6: one finished word lowers the count by exactly one
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.advance && !dpCtrl.load |=> remaining == $past(remaining) - CNT_W'(1));

  // R9: the count only moves on a load or an advance
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.load && !dpCtrl.advance |=> $stable(remaining));

  // R5: a failed confirmation leaves the failure code
  a_r5_fail_status: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.setFail |=> runStatus == STAT_FAIL);

  // R6: full success leaves the good code and nothing remaining
  a_r6_ok_status: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.setOk |=> runStatus == STAT_OK && remaining == '0);

endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
  import nor_prog_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   srcValid,
  input  logic   zeroCount,
  input  logic   lastWord,
  input  logic   pollOk,
  input  logic   dq5High,
  input  logic   dq7Only,
  output dpCtrlT dpCtrl,
  output logic   srcReady,
  output logic   flWe,
  output logic   flRe,
  output logic   busy,
  output logic   done
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_CMD1, ST_CMD2, ST_CMD3, ST_DATA,
    ST_POLL, ST_CHECK, ST_CONFIRM, ST_VERIFY, ST_DONE
  } stateE;

  stateE state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    dpCtrl    = '0;
    dpCtrl.busSel = BUS_DEST;
    srcReady  = 1'b0;
    flWe      = 1'b0;
    flRe      = 1'b0;
    case (state)
      ST_IDLE: if (startReq) begin
        dpCtrl.load = 1'b1;
        stateNext   = zeroCount ? ST_DONE : ST_FETCH;
      end
      ST_FETCH: begin
        srcReady = 1'b1;
        if (srcValid) begin
          dpCtrl.capture = 1'b1;
          stateNext      = ST_CMD1;
        end
      end
      ST_CMD1: begin flWe = 1'b1; dpCtrl.busSel = BUS_UNLOCK1; stateNext = ST_CMD2; end
      ST_CMD2: begin flWe = 1'b1; dpCtrl.busSel = BUS_UNLOCK2; stateNext = ST_CMD3; end
      ST_CMD3: begin flWe = 1'b1; dpCtrl.busSel = BUS_PROGCMD; stateNext = ST_DATA; end
      ST_DATA: begin flWe = 1'b1; stateNext = ST_POLL; end
      ST_POLL: begin flRe = 1'b1; stateNext = ST_CHECK; end
      ST_CHECK: begin
        if (pollOk) begin
          dpCtrl.advance = 1'b1;
          dpCtrl.setOk   = lastWord;
          stateNext      = lastWord ? ST_DONE : ST_FETCH;
        end else if (dq7Only || !dq5High) begin
          stateNext = ST_POLL;
        end else begin
          stateNext = ST_CONFIRM;
        end
      end
      ST_CONFIRM: begin flRe = 1'b1; stateNext = ST_VERIFY; end
      ST_VERIFY: begin
        if (pollOk) begin
          dpCtrl.advance = 1'b1;
          dpCtrl.setOk   = lastWord;
          stateNext      = lastWord ? ST_DONE : ST_FETCH;
        end else begin
          dpCtrl.setFail = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);

  // R9: end-of-run indication lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: the source is offered only inside a run, with the bus quiet
  a_r10_ready_in_run: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> busy && !flWe && !flRe);

  // R13: the cycle after a read strobe samples data and drives no strobe
  a_r13_sample_slot: assert property (@(posedge clk) disable iff (!rstN)
    flRe |=> !flRe && !flWe && busy);

  // R12: an idle start with no words finishes on the next cycle
  a_r12_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !busy && !done && zeroCount |=> done);

endmodule

// File: rtl/nor_prog_engine.sv
module nor_prog_engine
  import nor_prog_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              busy,
  output logic              done,
  output logic [7:0]        runStatus,
  output logic [CNT_W-1:0]  remaining,
  input  logic [ADDR_W-1:0] cfgUnlockAddr1,
  input  logic [ADDR_W-1:0] cfgUnlockAddr2,
  input  logic [DATA_W-1:0] cfgUnlockCmd1,
  input  logic [DATA_W-1:0] cfgUnlockCmd2,
  input  logic [DATA_W-1:0] cfgProgCmd,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [CNT_W-1:0]  cfgWordCount,
  input  logic [1:0]        cfgBusWidth,
  input  logic [DATA_W-1:0] cfgPollMask,
  input  logic              cfgDq7Only,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  output logic              srcReady,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWData,
  output logic              flWe,
  output logic              flRe,
  input  logic [DATA_W-1:0] flRData
);

  dpCtrlT dpCtrl;
  logic   zeroCount, lastWord, pollOk, dq5High, dq7Only;

  nor_prog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .srcValid  (srcValid),
    .zeroCount (zeroCount),
    .lastWord  (lastWord),
    .pollOk    (pollOk),
    .dq5High   (dq5High),
    .dq7Only   (dq7Only),
    .dpCtrl    (dpCtrl),
    .srcReady  (srcReady),
    .flWe      (flWe),
    .flRe      (flRe),
    .busy      (busy),
    .done      (done)
  );

  nor_prog_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .dpCtrl         (dpCtrl),
    .cfgUnlockAddr1 (cfgUnlockAddr1),
    .cfgUnlockAddr2 (cfgUnlockAddr2),
    .cfgUnlockCmd1  (cfgUnlockCmd1),
    .cfgUnlockCmd2  (cfgUnlockCmd2),
    .cfgProgCmd     (cfgProgCmd),
    .cfgStartAddr   (cfgStartAddr),
    .cfgWordCount   (cfgWordCount),
    .cfgBusWidth    (cfgBusWidth),
    .cfgPollMask    (cfgPollMask),
    .cfgDq7Only     (cfgDq7Only),
    .srcData        (srcData),
    .flRData        (flRData),
    .flAddr         (flAddr),
    .flWData        (flWData),
    .remaining      (remaining),
    .runStatus      (runStatus),
    .zeroCount      (zeroCount),
    .lastWord       (lastWord),
    .pollOk         (pollOk),
    .dq5High        (dq5High),
    .dq7Only        (dq7Only)
  );

endmodule

// File: tb/nor_prog_engine_tb.sv
module nor_prog_engine_tb;

  localparam int AW = 24;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam logic [AW-1:0] UA1 = 24'h000555;
  localparam logic [AW-1:0] UA2 = 24'h0002AA;
  localparam logic [DW-1:0] UC1 = 32'h00AA00AA;
  localparam logic [DW-1:0] UC2 = 32'h00550055;
  localparam logic [DW-1:0] PGC = 32'h00A000A0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic busy, done, srcReady, flWe, flRe;
  logic [7:0] runStatus;
  logic [CW-1:0] remaining;
  logic [AW-1:0] cfgStartAddr = '0;
  logic [CW-1:0] cfgWordCount = '0;
  logic [1:0] cfgBusWidth = '0;
  logic cfgDq7Only = 1'b0;
  logic [DW-1:0] srcData = '0;
  logic srcValid = 1'b0;
  logic [AW-1:0] flAddr;
  logic [DW-1:0] flWData;
  logic [DW-1:0] flRData = '0;

  always #10 clk = ~clk;

  nor_prog_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .done(done),
    .runStatus(runStatus), .remaining(remaining),
    .cfgUnlockAddr1(UA1), .cfgUnlockAddr2(UA2),
    .cfgUnlockCmd1(UC1), .cfgUnlockCmd2(UC2), .cfgProgCmd(PGC),
    .cfgStartAddr(cfgStartAddr), .cfgWordCount(cfgWordCount),
    .cfgBusWidth(cfgBusWidth), .cfgPollMask(32'h00000080), .cfgDq7Only(cfgDq7Only),
    .srcData(srcData), .srcValid(srcValid), .srcReady(srcReady),
    .flAddr(flAddr), .flWData(flWData), .flWe(flWe), .flRe(flRe), .flRData(flRData)
  );

  // per-word flash behaviour: 0 plain busy, 1 timeout then recover,
  // 2 timeout and stay busy, 3 timeout flag from the first read then recover
  int busyN [16];
  int kindW [16];
  logic [DW-1:0] wordsArr [16];

  int curBytes = 1;
  logic [DW-1:0] curMask = 32'hFF;
  logic [AW-1:0] curStart = '0;
  int runBase = 0;
  int srcBase = 0;

  int wIdx = 0, curW = 0, readK = 0, srcIdx = 0, slot = 0, writeCount = 0;
  int seqErr = 0, addrErr = 0;
  bit pendingFire = 1'b0;
  bit rdPending = 1'b0;
  logic [DW-1:0] respNext = '0;

  int testsRun = 0, testsFailed = 0;

  function automatic logic [AW-1:0] destOf(int w);
    return curStart + AW'(w * curBytes);
  endfunction

  function automatic logic [DW-1:0] respOf(int w, int k);
    logic [DW-1:0] good, b0, b1, r;
    good = wordsArr[w] & curMask;
    b0 = (good ^ 32'h80) & ~32'h20;
    b1 = (good ^ 32'h80) | 32'h20;
    case (kindW[w])
      0: r = (k < busyN[w]) ? b0 : good;
      1: r = (k < busyN[w]) ? b0 : ((k == busyN[w]) ? b1 : good);
      2: r = (k < busyN[w]) ? b0 : b1;
      default: r = (k < busyN[w]) ? b1 : good;
    endcase
    return r | (32'hA5A5A5A5 & ~curMask);
  endfunction

  // source stream and flash model, evaluated mid-cycle
  always @(negedge clk) begin
    if (pendingFire) srcIdx++;
    srcValid = ($urandom_range(0, 3) != 0);
    srcData  = wordsArr[(srcIdx - srcBase) & 15];
    pendingFire = srcValid && srcReady;
    rdPending = 1'b0;
    if (flWe) begin
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      writeCount++;
      case (slot)
        0: begin ea = UA1; ed = UC1 & curMask; end
        1: begin ea = UA2; ed = UC2 & curMask; end
        2: begin ea = UA1; ed = PGC & curMask; end
        default: begin
          curW = wIdx - runBase;
          ea = destOf(curW);
          ed = wordsArr[curW & 15] & curMask;
          wIdx++;
          readK = 0;
        end
      endcase
      if (flWData !== ed) seqErr++;
      if (flAddr !== ea) begin
        if (slot == 3) addrErr++; else seqErr++;
      end
      slot = (slot + 1) % 4;
    end
    if (flRe) begin
      if (flAddr !== destOf(curW)) addrErr++;
      respNext = respOf(curW & 15, readK);
      readK++;
      rdPending = 1'b1;
    end
  end

  always @(posedge clk) flRData <= rdPending ? respNext : 32'h5A5A0F0F;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runCase(int bw, int cnt, bit dq7, logic [AW-1:0] sa, bit poke);
    int failAt, expWords, cyc, busyErr, s0, a0, wc0;
    logic [7:0] expStat;
    logic [CW-1:0] expRem;
    failAt = -1;
    for (int w = 0; w < cnt; w++) begin
      if (!dq7 && (kindW[w] == 2 || (kindW[w] == 3 && busyN[w] >= 2))) begin
        failAt = w;
        break;
      end
    end
    expStat  = (failAt < 0) ? 8'h80 : 8'h00;
    expRem   = (failAt < 0) ? '0 : CW'(cnt - failAt);
    expWords = (failAt < 0) ? cnt : failAt + 1;
    @(negedge clk);
    curBytes = 1 << bw;
    curMask  = (bw == 0) ? 32'hFF : ((bw == 1) ? 32'hFFFF : 32'hFFFFFFFF);
    curStart = sa;
    runBase  = wIdx;
    srcBase  = srcIdx;
    s0 = seqErr; a0 = addrErr; wc0 = writeCount;
    cfgBusWidth = 2'(bw); cfgWordCount = CW'(cnt); cfgStartAddr = sa; cfgDq7Only = dq7;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (cnt == 0) chk(done && !busy, "R12", "done right after start", {done, busy}, 2'b10);
    else chk(busy && !done, "R9", "busy after start", {busy, done}, 2'b10);
    cyc = 0; busyErr = 0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 6) begin
        startReq = 1'b1; cfgWordCount = CW'(3); cfgStartAddr = ~sa;
      end
      if (poke && cyc == 7) begin
        startReq = 1'b0; cfgWordCount = CW'(cnt); cfgStartAddr = sa;
      end
      if (!done && !busy) busyErr++;
    end
    startReq = 1'b0;
    chk(done, "R9", "run finished before watchdog", done, 1);
    chk(busyErr == 0 && !busy, "R9", "busy held until done", busyErr, 0);
    chk(runStatus == expStat, (failAt < 0) ? "R6" : "R5", "final status", runStatus, expStat);
    chk(remaining == expRem, (failAt < 0) ? "R6" : "R5", "remaining count", remaining, expRem);
    chk(srcIdx - srcBase == expWords, "R10", "source words consumed", srcIdx - srcBase, expWords);
    chk(writeCount - wc0 == 4 * expWords, "R2", "write strobes", writeCount - wc0, 4 * expWords);
    chk(seqErr == s0, "R2", "command write order and values", seqErr - s0, 0);
    chk(addrErr == a0, "R7", "destination stepping and data lanes", addrErr - a0, 0);
    if (poke) chk(remaining == expRem && addrErr == a0, "R11", "mid-run start ignored", remaining, expRem);
    repeat (3) @(negedge clk);
    chk(!done && runStatus == expStat && remaining == expRem, "R9", "results held after done",
        {done, runStatus}, {1'b0, expStat});
    @(negedge clk);
  endtask

  task automatic setWords(int cnt, int kind, int n);
    for (int w = 0; w < 16; w++) begin
      wordsArr[w] = $urandom();
      kindW[w] = kind;
      busyN[w] = n + (w % 3);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    setWords(16, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !srcReady && !flWe && !flRe, "R1", "outputs in reset",
        {busy, done, srcReady, flWe, flRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !srcReady && !flWe && !flRe, "R1", "outputs after reset",
        {busy, done, srcReady, flWe, flRe}, 0);

    // R3 / R13: plain busy polling, 16-bit
    setWords(16, 0, 0);
    runCase(1, 3, 1'b0, 24'h001000, 1'b0);
    // R4: timeout flag then recovery on the confirming read, 8-bit
    setWords(16, 0, 1);
    kindW[1] = 1;
    runCase(0, 4, 1'b0, 24'h000010, 1'b0);
    // R5: timeout and still busy on word 2 of 5, 32-bit
    setWords(16, 0, 1);
    kindW[2] = 2;
    runCase(2, 5, 1'b0, 24'h00F000, 1'b0);
    // R8: timeout flag ignored in bit-7-only mode
    setWords(16, 0, 0);
    kindW[0] = 3; busyN[0] = 3;
    runCase(1, 2, 1'b1, 24'h000200, 1'b0);
    // R4 / R5: same pattern in the normal mode fails at word 0
    runCase(1, 2, 1'b0, 24'h000200, 1'b0);
    // R12: zero word count
    begin
      int wc0;
      wc0 = writeCount;
      runCase(2, 0, 1'b0, 24'h000400, 1'b0);
      chk(writeCount == wc0, "R12", "no flash access", writeCount - wc0, 0);
    end
    // R11: start pulse during a run
    setWords(16, 0, 2);
    runCase(0, 5, 1'b0, 24'h000800, 1'b1);
    // R7: address wrap at the top, 32-bit
    setWords(16, 0, 0);
    runCase(2, 3, 1'b0, 24'hFFFFF8, 1'b0);

    // constrained random runs
    for (int r = 0; r < 25; r++) begin
      int bw, cnt;
      bit dq7;
      bw  = $urandom_range(0, 2);
      cnt = $urandom_range(1, 8);
      dq7 = ($urandom_range(0, 3) == 0);
      for (int w = 0; w < 16; w++) begin
        int roll;
        wordsArr[w] = $urandom();
        roll = $urandom_range(0, 19);
        kindW[w] = (roll < 14) ? 0 : ((roll < 17) ? 1 : ((roll < 18 && !dq7) ? 2 : 3));
        busyN[w] = (kindW[w] == 3) ? $urandom_range(1, 4) : $urandom_range(0, 4);
      end
      runCase(bw, cnt, dq7, AW'($urandom()), (r % 7) == 3);
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule